// File: doc/BRIEF.md
# Bridge Interrupt Status Unit

This block collects interrupt events for a host bridge and turns them into three interrupt lines: one to the CPU, one onto the PCI side and one system-error line. Hardware sources pulse event inputs, and each pulse latches a bit in a 32-bit cause register. Software reads the cause register to see what happened. It acknowledges events by writing zeros to the bits it has handled, and ones to the bits it wants to leave alone. Bit 0 of the cause register is not storage. It always reads as a summary that is set when any other cause bit is set.

Three mask registers decide which causes reach which output. Each mask has its own fixed set of writable bits, and writes to the other bits are dropped. The outputs are computed combinationally from the stored cause and mask registers. A change to either register shows on the outputs in the cycle after the clock edge that stores it.

Registers are selected by a 2-bit code on both the write side and the read side. Reads are combinational.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, all four registers read 0 and `cpu_irq`, `pci_irq` and `err_irq` are low.
- R2: A write with select 0 (cause) replaces cause bits 31:1 with their AND with write data bits 31:1. A 0 clears the bit and a 1 leaves it unchanged.
- R3: Cause bit 0 always reads as the OR of stored cause bits 31:1. Write data bit 0 has no effect on it.
- R4: A high `ev_set[i]` at a clock edge sets cause bit i+1, readable from the next cycle. If a clearing write to the same bit happens in the same cycle, the bit is set.
- R5: A write with select 1 (CPU mask) stores only the bits of 0x3C3FFFFE from the write data. All other bits read 0.
- R6: A write with select 2 (PCI mask) stores only the bits of 0x03FFFFFE from the write data. All other bits read 0.
- R7: A write with select 3 (error mask) stores only bits 5:0 of the write data. All other bits read 0.
- R8: `cpu_irq` is high exactly when some bit in 31:1 is set in both the cause register and the CPU mask.
- R9: `pci_irq` is high exactly when some bit in 31:1 is set in both the cause register and the PCI mask.
- R10: `err_irq` is high exactly when some bit in 5:0 of the cause read value (bit 0 being the summary) is set together with the same bit of the error mask.
- R11: `rd_data` shows the register chosen by `rd_sel` combinationally (0 cause, 1 CPU mask, 2 PCI mask, 3 error mask). A write leaves the other three registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register selected for the read |
| rd_data | output | 32 | Read data |
| ev_set | input | 31 | Event pulses; bit i sets cause bit i+1 |
| cpu_irq | output | 1 | CPU interrupt request |
| pci_irq | output | 1 | PCI-side interrupt request |
| err_irq | output | 1 | System-error request |

## Verification
Several properties are checked on every cycle:
- A cause bit raised by an event is present after the edge, even while a clearing write is under way.
- A write never leaves set a bit that was written as zero and had no event.
- Cause and masks hold still when nothing touches them.
- Unwritable mask bits stay zero.
- Each output stays low while its mask is empty.
- A cause read always carries a consistent summary bit.

Only the bench scenarios can show the exact values:
- the AND semantics across several write patterns;
- the mask filtering, including a cause bit outside the CPU mask's writable set that never reaches `cpu_irq`;
- the error line being driven through the summary bit.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

  localparam int REG_W  = 32;
  localparam int ERR_W  = 6;
  localparam int N_MASK = 3;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CAUSE    = 2'd0,
    SEL_CPU_MASK = 2'd1,
    SEL_PCI_MASK = 2'd2,
    SEL_ERR_MASK = 2'd3
  } reg_sel_e;

  localparam logic [REG_W-1:0] CPU_KEEP = 32'h3C3F_FFFE;
  localparam logic [REG_W-1:0] PCI_KEEP = 32'h03FF_FFFE;
  localparam logic [REG_W-1:0] ERR_KEEP = REG_W'((64'd1 << ERR_W) - 64'd1);

  // Writable-bit set of mask register number idx (0 CPU, 1 PCI, 2 error).
  function automatic logic [REG_W-1:0] keep_of(input int idx);
    case (idx)
      0:       keep_of = CPU_KEEP;
      1:       keep_of = PCI_KEEP;
      default: keep_of = ERR_KEEP;
    endcase
  endfunction

  // Next stored cause bits: clear-by-zero write, then events override.
  function automatic logic [REG_W-2:0] cause_next(input logic [REG_W-2:0] cur,
                                                  input logic             wr,
                                                  input logic [REG_W-2:0] wdata,
                                                  input logic [REG_W-2:0] ev);
    logic [REG_W-2:0] kept;
    kept = wr ? (cur & wdata) : cur;
    cause_next = kept | ev;
  endfunction

  // Read view of the cause register: stored bits plus summary at bit 0.
  function automatic logic [REG_W-1:0] cause_view(input logic [REG_W-2:0] bits);
    cause_view = {bits, |bits};
  endfunction

  function automatic logic [REG_W-1:0] mask_filter(input logic [REG_W-1:0] wdata,
                                                   input logic [REG_W-1:0] keep);
    mask_filter = wdata & keep;
  endfunction

endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
  import irq_stat_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_cause,
  input  logic [W-1:1] wr_bits,
  input  logic [W-1:1] ev_set,
  output logic [W-1:0] cause_rd
);

  logic [W-1:1] cause_q;
  logic [W-1:1] cause_d;

  always_comb cause_d = cause_next(cause_q, wr_cause, wr_bits, ev_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  always_comb cause_rd = cause_view(cause_q);

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set != '0) |=> ((cause_q & $past(ev_set)) == $past(ev_set))); // R4

  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cause |=> ((cause_q & ~$past(wr_bits) & ~$past(ev_set)) == '0)); // R2

  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cause && ev_set == '0) |=> $stable(cause_q)); // R11

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_stat_pkg::*;
#(
  parameter int           W    = REG_W,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= '0;
    else if (wr) mask_q <= mask_filter(wdata, KEEP);
  end

  AST_MASK_FIXED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & ~KEEP) == '0); // R5

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mask_q)); // R11

endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen
  import irq_stat_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int EW = ERR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  cause_rd,
  input  logic [W-1:1]  cpu_mask,
  input  logic [W-1:1]  pci_mask,
  input  logic [EW-1:0] err_mask,
  output logic          cpu_irq,
  output logic          pci_irq,
  output logic          err_irq
);

  logic [W-1:1]  cpu_hits;
  logic [W-1:1]  pci_hits;
  logic [EW-1:0] err_hits;

  always_comb begin
    cpu_hits = cause_rd[W-1:1] & cpu_mask;
    pci_hits = cause_rd[W-1:1] & pci_mask;
    err_hits = cause_rd[EW-1:0] & err_mask;
    cpu_irq  = |cpu_hits;
    pci_irq  = |pci_hits;
    err_irq  = |err_hits;
  end

  AST_CPU_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_mask == '0) |-> !cpu_irq); // R8

  AST_PCI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_mask == '0) |-> !pci_irq); // R9

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (err_mask == '0) |-> !err_irq); // R10

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic [REG_W-2:0] ev_set,
  output logic             cpu_irq,
  output logic             pci_irq,
  output logic             err_irq
);

  logic             wr_cause;
  logic [REG_W-1:0] cause_rd;
  logic [REG_W-1:0] mask_q [N_MASK];

  assign wr_cause = wr_en && (wr_sel == SEL_CAUSE);

  irq_cause_reg #(.W(REG_W)) u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cause (wr_cause),
    .wr_bits  (wr_data[REG_W-1:1]),
    .ev_set   (ev_set),
    .cause_rd (cause_rd)
  );

  for (genvar g = 0; g < N_MASK; g++) begin : g_mask
    logic wr_this;
    assign wr_this = wr_en && (wr_sel == SEL_W'(g + 1));
    irq_mask_reg #(.W(REG_W), .KEEP(keep_of(g))) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_this),
      .wdata  (wr_data),
      .mask_q (mask_q[g])
    );
  end

  irq_out_gen #(.W(REG_W), .EW(ERR_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .cause_rd (cause_rd),
    .cpu_mask (mask_q[0][REG_W-1:1]),
    .pci_mask (mask_q[1][REG_W-1:1]),
    .err_mask (mask_q[2][ERR_W-1:0]),
    .cpu_irq  (cpu_irq),
    .pci_irq  (pci_irq),
    .err_irq  (err_irq)
  );

  always_comb begin
    case (rd_sel)
      SEL_CAUSE:    rd_data = cause_rd;
      SEL_CPU_MASK: rd_data = mask_q[0];
      SEL_PCI_MASK: rd_data = mask_q[1];
      default:      rd_data = mask_q[2];
    endcase
  end

  AST_SUMMARY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_CAUSE) |-> (rd_data[0] == (rd_data[REG_W-1:1] != '0))); // R3

endmodule

// File: tb/irq_status_unit_test.sv
`timescale 1ns/1ps
module irq_status_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic [30:0] ev_set = 31'd0;
  logic        cpu_irq, pci_irq, err_irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Bench-side copy of the stored cause bits (index k = cause bit k+1).
  logic [30:0] m_cause = 31'd0;

  always #4 clk = ~clk;

  irq_status_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .ev_set(ev_set), .cpu_irq(cpu_irq), .pci_irq(pci_irq), .err_irq(err_irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_cause();
    logic any = 1'b0;
    for (int k = 0; k < 31; k++) if (m_cause[k]) any = 1'b1;
    return {m_cause, any};
  endfunction

  // One cycle of stimulus; the model follows the rules in the brief.
  task automatic cycle(input logic wr, input logic [1:0] sel,
                       input logic [31:0] data, input logic [30:0] ev);
    @(negedge clk);
    wr_en = wr; wr_sel = sel; wr_data = data; ev_set = ev;
    @(negedge clk);
    wr_en = 1'b0; ev_set = 31'd0;
    for (int k = 0; k < 31; k++) begin
      if (ev[k]) m_cause[k] = 1'b1;
      else if (wr && sel == 2'd0 && !data[k+1]) m_cause[k] = 1'b0;
    end
  endtask

  task automatic read_chk(input string req, input logic [1:0] sel, input logic [31:0] exp);
    rd_sel = sel;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic t_reset();
    read_chk("R1 cause", 2'd0, 32'h0);
    read_chk("R1 cpu mask", 2'd1, 32'h0);
    read_chk("R1 pci mask", 2'd2, 32'h0);
    read_chk("R1 err mask", 2'd3, 32'h0);
    check("R1 outputs", {29'd0, cpu_irq, pci_irq, err_irq}, 32'h0);
  endtask

  task automatic t_events();
    cycle(1'b0, 2'd0, 32'h0, 31'h1);
    read_chk("R4 single event", 2'd0, 32'h0000_0003);
    cycle(1'b0, 2'd0, 32'h0, 31'h2);
    read_chk("R4 second event", 2'd0, exp_cause());
    check("R4 value", rd_data, 32'h0000_0007);
  endtask

  task automatic t_clear();
    cycle(1'b1, 2'd0, 32'hFFFF_FFFB, 31'h0);
    read_chk("R2 clear one bit", 2'd0, 32'h0000_0003);
    cycle(1'b1, 2'd0, 32'hFFFF_FFFF, 31'h0);
    read_chk("R2 ones keep", 2'd0, 32'h0000_0003);
    cycle(1'b1, 2'd0, 32'h0000_0001, 31'h0);
    read_chk("R3 bit0 write ignored, summary low", 2'd0, 32'h0);
    check("R3 model", exp_cause(), 32'h0);
  endtask

  task automatic t_set_wins();
    cycle(1'b0, 2'd0, 32'h0, 31'h10);
    cycle(1'b1, 2'd0, 32'h0, 31'h10);
    read_chk("R4 set beats clear", 2'd0, 32'h0000_0021);
  endtask

  task automatic t_masks();
    cycle(1'b1, 2'd1, 32'hFFFF_FFFF, 31'h0);
    read_chk("R5 cpu mask keep", 2'd1, 32'h3C3F_FFFE);
    read_chk("R11 cause untouched by mask write", 2'd0, exp_cause());
    cycle(1'b1, 2'd2, 32'hFFFF_FFFF, 31'h0);
    read_chk("R6 pci mask keep", 2'd2, 32'h03FF_FFFE);
    cycle(1'b1, 2'd3, 32'hFFFF_FFFF, 31'h0);
    read_chk("R7 err mask keep", 2'd3, 32'h0000_003F);
    read_chk("R11 cpu mask untouched", 2'd1, 32'h3C3F_FFFE);
  endtask

  task automatic t_outputs();
    // cause = 0x21 (bit 5), all masks full from t_masks
    #1 check("R8 cpu high", {31'd0, cpu_irq}, 32'd1);
    check("R9 pci high", {31'd0, pci_irq}, 32'd1);
    check("R10 err high", {31'd0, err_irq}, 32'd1);
    cycle(1'b1, 2'd1, 32'h0, 31'h0);
    #1 check("R8 cpu low, mask empty", {31'd0, cpu_irq}, 32'd0);
    // only cause bit 30: outside both CPU and PCI writable sets
    cycle(1'b1, 2'd0, 32'h0, 31'h2000_0000);
    cycle(1'b1, 2'd1, 32'hFFFF_FFFF, 31'h0);
    read_chk("R4 bit30", 2'd0, 32'h4000_0001);
    check("R8 bit30 masked off", {31'd0, cpu_irq}, 32'd0);
    check("R9 bit30 masked off", {31'd0, pci_irq}, 32'd0);
    check("R10 via summary", {31'd0, err_irq}, 32'd1);
    cycle(1'b1, 2'd3, 32'h0000_0002, 31'h0);
    #1 check("R10 bit1 mask, no bit1 cause", {31'd0, err_irq}, 32'd0);
    cycle(1'b0, 2'd0, 32'h0, 31'h1);
    #1 check("R10 bit1 cause", {31'd0, err_irq}, 32'd1);
    check("R8 bit1 cause", {31'd0, cpu_irq}, 32'd1);
    cycle(1'b1, 2'd2, 32'h0000_0004, 31'h0);
    #1 check("R9 pci mask other bit", {31'd0, pci_irq}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_events();
    t_clear();
    t_set_wins();
    t_masks();
    t_outputs();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule